// File: doc/BRIEF.md
# Two-Channel Transfer Start/Stop Control

This block holds the control state for the two channels of a transfer controller. Each channel has one byte-wide control register with two live fields: an enable flag and a status flag. The enable flag turns the channel on and gates its clock. The status flag arms the channel, and it stays set for as long as a transfer is pending or running. An armed and enabled channel waits for a start event. The start event is either a software trigger or one hardware request picked by a 4-bit select field. When the start event comes, the block pulses a start strobe to an external transfer engine.

The engine reports completion on a done input. The channel then drops its status flag on its own and pulses a completion interrupt. Software may instead clear the status flag while a transfer runs. That ends the transfer early: the block pulses an abort strobe to the engine and raises no interrupt. The enable flag is protected. It can change only while status is clear. It also cannot change for a short window after a clock-source select input goes high. Software therefore shuts a channel down by clearing status first and enable second.

Each channel runs a three-state machine:
- `CH_IDLE`: status is 0.
- `CH_ARMED`: status is 1 and no transfer is running.
- `CH_XFER`: the engine is busy.

The transitions are:
- `CH_IDLE`→`CH_ARMED` when status is written to 1.
- `CH_ARMED`→`CH_XFER` when the channel is enabled and a trigger arrives.
- `CH_ARMED`→`CH_IDLE` when status is written to 0. This is a quiet disarm.
- `CH_XFER`→`CH_IDLE` when done arrives. This is completion.
- `CH_XFER`→`CH_IDLE` when status is written to 0. This is forced termination.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: Each channel register reads as 8 bits, with enable in bit 7 and status in bit 0. Bits 6..1 always read as 0. `reg_sel` picks the channel shown on `reg_rdata`.
- R2: After reset, both registers read 0x00. All strobes, interrupts and clock enables are 0.
- R3: A write with `reg_bit_mode`=0 updates bit 7 from `reg_wdata[7]` and bit 0 from `reg_wdata[0]`. A write with `reg_bit_mode`=1 updates only bit `reg_bit_idx` from `reg_wdata[0]`. Writes to bits 6..1 have no effect.
- R4: A write to the enable bit is ignored while the channel's status bit is 1, as sampled before the write.
- R5: `ch_clk_en[n]` equals the channel's enable bit. A channel with enable 0 never pulses `eng_start`.
- R6: A channel with enable 1 and status 1 that is not transferring starts a transfer on `sw_trig[n]`, or on `hw_src[k]` where k is `src_sel[4n+3:4n]`. `eng_start[n]` goes high for exactly one cycle, in the cycle after the trigger is sampled. Status stays 1.
- R7: When `eng_done[n]` is sampled during a transfer, status clears to 0 and `irq_done[n]` pulses for one cycle in the next cycle.
- R8: Writing status to 0 during a transfer pulses `eng_abort[n]` for one cycle in the next cycle and raises no interrupt. Writing status to 0 while only armed gives no abort.
- R9: If `eng_done[n]` and a status-clear write fall in the same cycle, completion wins. `irq_done[n]` pulses and `eng_abort[n]` does not.
- R10: Enable writes are ignored in the cycle in which `clk_sel` is first sampled high, and in the LOCK_CYCLES (default 3) cycles that follow.
- R11: A trigger sampled while the channel is idle, disabled or already transferring is dropped. It is not stored and never causes a later start.
- R12: The two channels are independent. Writes, triggers and engine events on one channel leave the other channel's register and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Channel select for read and write |
| reg_bit_mode | input | 1 | 1 = single-bit write, 0 = byte write |
| reg_bit_idx | input | 3 | Bit index for a single-bit write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register of the selected channel |
| clk_sel | input | 1 | Clock-source select level; a rising edge starts the enable lockout |
| src_sel | input | 8 | Hardware start source select, 4 bits per channel |
| hw_src | input | 16 | Hardware start requests |
| sw_trig | input | 2 | Software trigger per channel |
| eng_done | input | 2 | Engine completion per channel |
| eng_start | output | 2 | One-cycle start strobe to the engine |
| eng_abort | output | 2 | One-cycle abort strobe to the engine |
| irq_done | output | 2 | One-cycle completion interrupt |
| ch_clk_en | output | 2 | Per-channel clock enable |

## Verification
Two events can land on the same running channel in one cycle: the engine's completion and software's status-clear write. The bench provokes this by driving `eng_done` and a single-bit status clear in the same cycle on a transferring channel. It then expects exactly one interrupt event, no abort event, and status read back as 0 (R9). The quiet case, a status clear while only armed, is also covered. The bench checks that no strobe appears at all, because the scoreboard rejects any event it did not queue.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_XFER  = 2'd2
    } ch_state_e;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned EN_POS    = 7;
    localparam int unsigned ST_POS    = 0;
    localparam int unsigned BIT_IDX_W = 3;

endpackage

// File: rtl/dmac_lockout.sv
module dmac_lockout #(
    parameter int unsigned LOCK_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    output logic lock
);
    localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);

    logic          sel_q;
    logic [CW-1:0] cnt_q;
    logic          rise;

    assign rise = clk_sel && !sel_q;
    assign lock = rise || (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            sel_q <= clk_sel;
            if (rise) begin
                cnt_q <= CW'(LOCK_CYCLES);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_LOCK_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel) |=> lock); // R10

endmodule

// File: rtl/dmac_trig_sel.sv
module dmac_trig_sel #(
    parameter int unsigned NSRC = 16,
    parameter int unsigned SELW = 4
) (
    input  logic [NSRC-1:0] hw_src,
    input  logic [SELW-1:0] sel,
    input  logic            sw_trig,
    output logic            trig
);
    logic hw_hit;

    always_comb begin
        hw_hit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SELW'(i)) begin
                hw_hit = hw_src[i];
            end
        end
    end

    assign trig = sw_trig || hw_hit;

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic en_wr,
    input  logic en_val,
    input  logic st_wr,
    input  logic st_val,
    input  logic trig,
    input  logic eng_done,
    output logic en_o,
    output logic st_o,
    output logic eng_start,
    output logic eng_abort,
    output logic irq
);
    ch_state_e state_q, state_d;
    logic      en_q;
    logic      st_clear;

    assign st_clear = st_wr && !st_val;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (st_wr && st_val) state_d = CH_ARMED;
            end
            CH_ARMED: begin
                if (st_clear)          state_d = CH_IDLE;
                else if (en_q && trig) state_d = CH_XFER;
            end
            CH_XFER: begin
                if (eng_done)      state_d = CH_IDLE;
                else if (st_clear) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (en_wr && (state_q == CH_IDLE) && !lock) en_q <= en_val;
            eng_start <= (state_q == CH_ARMED) && (state_d == CH_XFER);
            irq       <= (state_q == CH_XFER) && eng_done;
            eng_abort <= (state_q == CH_XFER) && !eng_done && st_clear;
        end
    end

    assign en_o = en_q;
    assign st_o = (state_q != CH_IDLE);

    AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE) |=> $stable(en_q)); // R4
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> en_q); // R5
    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start); // R6
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_XFER) && eng_done) |=> (irq && (state_q == CH_IDLE))); // R7
    AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |-> !irq); // R8
    AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_XFER) && eng_done && st_clear) |=> !eng_abort); // R9
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && en_wr) |=> $stable(en_q)); // R10
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_IDLE) && trig) |=> !eng_start); // R11

endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
    import dmac_pkg::*;
#(
    parameter int unsigned NCH         = 2,
    parameter int unsigned NSRC        = 16,
    parameter int unsigned SELW        = 4,
    parameter int unsigned LOCK_CYCLES = 3,
    localparam int unsigned CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [CHW-1:0]        reg_sel,
    input  logic                  reg_bit_mode,
    input  logic [BIT_IDX_W-1:0]  reg_bit_idx,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  clk_sel,
    input  logic [NCH*SELW-1:0]   src_sel,
    input  logic [NSRC-1:0]       hw_src,
    input  logic [NCH-1:0]        sw_trig,
    input  logic [NCH-1:0]        eng_done,
    output logic [NCH-1:0]        eng_start,
    output logic [NCH-1:0]        eng_abort,
    output logic [NCH-1:0]        irq_done,
    output logic [NCH-1:0]        ch_clk_en
);
    logic             lock;
    logic [NCH-1:0]   en_bits;
    logic [NCH-1:0]   st_bits;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[EN_POS-1:ST_POS+1];

    dmac_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .lock    (lock)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit, en_wr, en_val, st_wr, st_val, trig;

        assign hit    = reg_wr && (reg_sel == CHW'(g));
        assign en_wr  = hit && (!reg_bit_mode || (reg_bit_idx == BIT_IDX_W'(EN_POS)));
        assign st_wr  = hit && (!reg_bit_mode || (reg_bit_idx == BIT_IDX_W'(ST_POS)));
        assign en_val = reg_bit_mode ? reg_wdata[0] : reg_wdata[EN_POS];
        assign st_val = reg_wdata[ST_POS];

        dmac_trig_sel #(.NSRC(NSRC), .SELW(SELW)) u_tsel (
            .hw_src  (hw_src),
            .sel     (src_sel[g*SELW +: SELW]),
            .sw_trig (sw_trig[g]),
            .trig    (trig)
        );

        dmac_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .lock      (lock),
            .en_wr     (en_wr),
            .en_val    (en_val),
            .st_wr     (st_wr),
            .st_val    (st_val),
            .trig      (trig),
            .eng_done  (eng_done[g]),
            .en_o      (en_bits[g]),
            .st_o      (st_bits[g]),
            .eng_start (eng_start[g]),
            .eng_abort (eng_abort[g]),
            .irq       (irq_done[g])
        );
    end

    assign ch_clk_en = en_bits;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_sel == CHW'(i)) begin
                reg_rdata[EN_POS] = en_bits[i];
                reg_rdata[ST_POS] = st_bits[i];
            end
        end
    end

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[EN_POS-1:ST_POS+1] == '0); // R1
    AST_CLK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start & ~ch_clk_en) == '0); // R5

endmodule

// File: tb/dmac_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dmac_chan_ctrl_tb;

    typedef struct {
        int    ch;
        int    kind;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [0:0] reg_sel = '0;
    logic       reg_bit_mode = 1'b0;
    logic [2:0] reg_bit_idx = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       clk_sel = 1'b0;
    logic [7:0] src_sel = '0;
    logic [15:0] hw_src = '0;
    logic [1:0] sw_trig = '0;
    logic [1:0] eng_done = '0;
    logic [1:0] eng_start, eng_abort, irq_done, ch_clk_en;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    dmac_chan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_bit_mode(reg_bit_mode), .reg_bit_idx(reg_bit_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_sel(clk_sel),
        .src_sel(src_sel), .hw_src(hw_src), .sw_trig(sw_trig),
        .eng_done(eng_done), .eng_start(eng_start), .eng_abort(eng_abort),
        .irq_done(irq_done), .ch_clk_en(ch_clk_en)
    );

    // kind: 0 = start, 1 = abort, 2 = interrupt
    task automatic expect_ev(input int ch, input int kind, input string req);
        exp_t e;
        e.ch = ch; e.kind = kind; e.req = req;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int k = 0; k < 3; k++) begin
                    logic p;
                    exp_t e;
                    p = (k == 0) ? eng_start[ch] : (k == 1) ? eng_abort[ch] : irq_done[ch];
                    if (p) begin
                        checks++;
                        if (exp_q.size() == 0) begin
                            errors++;
                            $display("FAIL unexpected event: actual ch%0d kind%0d, expected none", ch, k);
                        end else begin
                            e = exp_q.pop_front();
                            if (e.ch != ch || e.kind != k) begin
                                errors++;
                                $display("FAIL %s: actual ch%0d kind%0d, expected ch%0d kind%0d",
                                         e.req, ch, k, e.ch, e.kind);
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h, expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input int ch, input int exp, input string req);
        reg_sel = ch[0:0];
        #0.1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic drained(input string req);
        check(req, exp_q.size(), 0);
    endtask

    task automatic wr_byte(input int ch, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = ch[0:0]; reg_bit_mode = 1'b0; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr_bit(input int ch, input int idx, input logic v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = ch[0:0]; reg_bit_mode = 1'b1;
        reg_bit_idx = idx[2:0]; reg_wdata = {7'd0, v};
        @(negedge clk);
        reg_wr = 1'b0; reg_bit_mode = 1'b0;
    endtask

    task automatic pulse_sw(input int ch);
        @(negedge clk); sw_trig[ch] = 1'b1;
        @(negedge clk); sw_trig[ch] = 1'b0;
    endtask

    task automatic pulse_hw(input int k);
        @(negedge clk); hw_src[k] = 1'b1;
        @(negedge clk); hw_src[k] = 1'b0;
    endtask

    task automatic pulse_done(input int ch);
        @(negedge clk); eng_done[ch] = 1'b1;
        @(negedge clk); eng_done[ch] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        chk_reg(0, 8'h00, "R2 ch0 reset");
        chk_reg(1, 8'h00, "R2 ch1 reset");
        check("R2 outputs", int'({eng_start, eng_abort, irq_done, ch_clk_en}), 0);

        // R1/R3 byte write sets enable and status, pad bits read 0
        wr_byte(0, 8'hFF);
        chk_reg(0, 8'h81, "R1 R3 byte write");
        check("R5 clk enable ch0", int'(ch_clk_en), 2'b01);
        // R6 software start
        expect_ev(0, 0, "R6 sw start");
        pulse_sw(0);
        idle(1);
        drained("R6 start seen");
        chk_reg(0, 8'h81, "R6 status held");
        // R7 completion
        expect_ev(0, 2, "R7 irq");
        pulse_done(0);
        idle(1);
        drained("R7 irq seen");
        chk_reg(0, 8'h80, "R7 status cleared");

        // R3 bit writes on ch1
        wr_bit(1, 7, 1'b1);
        chk_reg(1, 8'h80, "R3 bit7 write");
        wr_bit(1, 0, 1'b1);
        chk_reg(1, 8'h81, "R3 bit0 write");
        wr_bit(1, 3, 1'b1);
        chk_reg(1, 8'h81, "R3 pad bit write ignored");

        // R6 hardware source select
        src_sel[7:4] = 4'd5;
        pulse_hw(4);
        idle(2);
        drained("R6 unselected source ignored");
        expect_ev(1, 0, "R6 hw start");
        pulse_hw(5);
        idle(1);
        drained("R6 hw start seen");
        // R8 forced termination
        expect_ev(1, 1, "R8 abort");
        wr_byte(1, 8'h80);
        idle(1);
        drained("R8 abort seen");
        chk_reg(1, 8'h80, "R8 status cleared, enable kept");
        chk_reg(0, 8'h80, "R12 ch0 untouched");

        // R4 enable locked while status set
        wr_bit(0, 0, 1'b1);
        wr_byte(0, 8'h01);
        chk_reg(0, 8'h81, "R4 byte enable clear ignored");
        wr_bit(0, 7, 1'b0);
        chk_reg(0, 8'h81, "R4 bit enable clear ignored");
        // R8 quiet disarm, no abort
        wr_bit(0, 0, 1'b0);
        idle(2);
        drained("R8 no abort when armed only");
        chk_reg(0, 8'h80, "R8 disarm");
        wr_bit(0, 7, 1'b0);
        chk_reg(0, 8'h00, "R4 enable clear after status");

        // R5 disabled channel never starts
        wr_bit(0, 0, 1'b1);
        chk_reg(0, 8'h01, "R5 armed but disabled");
        pulse_sw(0);
        idle(3);
        check("R5 clk gated ch0", int'(ch_clk_en[0]), 0);
        wr_bit(0, 0, 1'b0);

        // R11 dropped triggers
        wr_byte(0, 8'h80);
        pulse_sw(0);
        wr_bit(0, 0, 1'b1);
        idle(5);
        drained("R11 idle trigger dropped");
        expect_ev(0, 0, "R11 start after fresh trigger");
        pulse_sw(0);
        pulse_sw(0);
        idle(2);
        drained("R11 trigger in transfer ignored");
        // R9 collision of done and status clear
        expect_ev(0, 2, "R9 completion wins");
        @(negedge clk);
        eng_done[0] = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b0; reg_bit_mode = 1'b1;
        reg_bit_idx = 3'd0; reg_wdata = 8'h00;
        @(negedge clk);
        eng_done[0] = 1'b0; reg_wr = 1'b0; reg_bit_mode = 1'b0;
        idle(2);
        drained("R9 irq only");
        chk_reg(0, 8'h80, "R9 status cleared");

        // R10 clock-select lockout on ch1
        wr_byte(1, 8'h00);
        chk_reg(1, 8'h00, "R10 prep");
        @(negedge clk);
        clk_sel = 1'b1;
        wr_byte(1, 8'h80);
        chk_reg(1, 8'h00, "R10 blocked first");
        wr_byte(1, 8'h80);
        chk_reg(1, 8'h00, "R10 blocked last window cycle");
        wr_byte(1, 8'h80);
        chk_reg(1, 8'h80, "R10 accepted after window");
        clk_sel = 1'b0;
        chk_reg(0, 8'h80, "R12 ch0 unaffected");

        idle(3);
        drained("final queue empty");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule